// File: doc/BRIEF.md
# DMA Byte Handshake Sequencer for a Parallel Storage Bus

This block moves bytes one at a time between a host-side DMA controller and a parallel storage bus data path. On the host side it paces each byte with a request/acknowledge pair (request out, acknowledge in, active low) and with the host's read and write strobes. It offers two pacing styles. In interlocked mode, each byte ends when the host acknowledge is released. In block mode, the host may hold its acknowledge low for the whole run, each byte ends when the strobe is released, and a ready output asks for the next byte. On the storage bus side it runs the per-byte REQ/ACK exchange by itself. As target it raises REQ and waits for ACK. As initiator it answers the remote REQ with its own ACK.

Three start strobes, one for each transfer kind, launch a run: send, target receive and initiator receive. Software control bits are sampled as live inputs: the DMA enable, the target role, block pacing and data-bus drive. A start strobe is accepted only when these bits are consistent with it. A run continues byte after byte until the DMA enable bit is cleared. The end-of-process input only leaves a sticky flag. A second sticky flag reports chip select and host acknowledge active in the same cycle.

Top module: `scsi_dma_handshake`

## Requirements
- R1: While dma_mode is 0, a start strobe is ignored: busy stays 0 and no request is raised on either side.
- R2: A target-receive start is accepted only with target_mode = 1. An initiator-receive start is accepted only with target_mode = 0. Otherwise busy stays 0. If several start strobes arrive in one cycle, only the highest-priority one is judged, in the order send, target receive, initiator receive.
- R3: A send start is accepted only with assert_data = 1. Send takes its bus role from target_mode. A send begins with a host request in the cycle after the start.
- R4: With block_mode = 0 (interlocked), drq is 1 while a byte is awaited and drops once dack_n is 0. The byte ends, pulsing byte_done for one cycle, on the first cycle dack_n is back at 1. Strobe release alone does not end the byte.
- R5: With block_mode = 1, rdy is 1 (drq stays 0) while a byte is awaited. The relevant strobe (iow_n for send, ior_n for receive) going low while dack_n is 0 takes the byte. Its return to 1 ends the byte even if dack_n stays 0. dack_n low alone does not take a byte.
- R6: In the initiator role, scsi_ack_o rises in the cycle after scsi_req_i is seen high. It stays high while scsi_req_i stays high, and falls in the cycle after scsi_req_i is seen low.
- R7: In the target role, scsi_req_o is 1 while a bus byte is awaited. It falls in the cycle after scsi_ack_i is seen high. The block waits for scsi_ack_i low before serving the host. scsi_req_o and scsi_ack_o are never both 1.
- R8: A run stops only when dma_mode is 0: busy falls in the next cycle and all request outputs drop. eop_n low during a run does not stop it and sets eop_seen, which an accepted start clears.
- R9: cs_n and dack_n both 0 in a cycle sets cs_dack_err from the next cycle. An accepted start clears it unless the condition is present in that same cycle.
- R10: On a receive, scsi_din is latched when the bus byte is taken and shown on host_rdata. On a send, host_wdata is latched while iow_n and dack_n are both 0. It drives scsi_dout, and scsi_dout_en is 1 only during the bus exchange of a send with assert_data = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_mode | input | 1 | DMA enable control bit |
| target_mode | input | 1 | 1 selects the target role on the bus |
| block_mode | input | 1 | 1 selects block pacing, 0 interlocked |
| assert_data | input | 1 | Data-bus drive control bit, required for send |
| start_send_wr | input | 1 | Start strobe for a send |
| start_trecv_wr | input | 1 | Start strobe for a target receive |
| start_irecv_wr | input | 1 | Start strobe for an initiator receive |
| cs_n | input | 1 | Host chip select, active low |
| dack_n | input | 1 | Host DMA acknowledge, active low |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| eop_n | input | 1 | End-of-process from the DMA controller, active low |
| host_wdata | input | DATA_W | Byte written by the host |
| host_rdata | output | DATA_W | Byte offered to the host |
| drq | output | 1 | DMA request, interlocked pacing |
| rdy | output | 1 | Ready for next byte, block pacing |
| scsi_req_i | input | 1 | Remote REQ seen in the initiator role |
| scsi_ack_i | input | 1 | Remote ACK seen in the target role |
| scsi_req_o | output | 1 | REQ driven in the target role |
| scsi_ack_o | output | 1 | ACK driven in the initiator role |
| scsi_din | input | DATA_W | Bus data in |
| scsi_dout | output | DATA_W | Bus data out |
| scsi_dout_en | output | 1 | Bus data drive enable |
| busy | output | 1 | A run is in progress |
| byte_done | output | 1 | One-cycle pulse when a host byte ends |
| eop_seen | output | 1 | Sticky: end-of-process seen during the run |
| cs_dack_err | output | 1 | Sticky: chip select and acknowledge active together |

## Verification
The assertions check several rules on every cycle: start rejection for a disabled, mis-roled or undriven send, stopping on a cleared enable, end-of-process not stopping a run, and the error flag following a select/acknowledge clash. They also check the initiator ACK's cause and hold, and that request and acknowledge are never driven together. Only the bench scenarios can show the full byte sequences. These include the end of a byte on acknowledge release versus strobe release, held acknowledge across bytes in block pacing, and the bytes actually carried through the holding register in each direction.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_ACQ,
        ST_BUS_REL,
        ST_HOST_REQ,
        ST_HOST_END
    } sdh_state_e;

    typedef enum logic [1:0] {
        XK_SEND,
        XK_TRECV,
        XK_IRECV
    } xfer_kind_e;

endpackage

// File: rtl/sdh_start_gate.sv
module sdh_start_gate
    import sdh_pkg::*;
(
    input  logic       dma_mode,
    input  logic       target_mode,
    input  logic       assert_data,
    input  logic       start_send_wr,
    input  logic       start_trecv_wr,
    input  logic       start_irecv_wr,
    input  logic       idle,
    output logic       accept,
    output xfer_kind_e kind
);

    logic consistent;

    always_comb begin
        kind       = XK_SEND;
        consistent = 1'b0;
        if (start_send_wr) begin
            kind       = XK_SEND;
            consistent = assert_data;
        end else if (start_trecv_wr) begin
            kind       = XK_TRECV;
            consistent = target_mode;
        end else if (start_irecv_wr) begin
            kind       = XK_IRECV;
            consistent = !target_mode;
        end
        accept = idle && dma_mode && consistent;
    end

endmodule

// File: rtl/sdh_edge_det.sv
module sdh_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_n,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= sig_n[i];
        end
        assign rise[i] = !prev_q[i] && sig_n[i];
    end

endmodule

// File: rtl/scsi_dma_handshake.sv
module scsi_dma_handshake
    import sdh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_mode,
    input  logic              target_mode,
    input  logic              block_mode,
    input  logic              assert_data,
    input  logic              start_send_wr,
    input  logic              start_trecv_wr,
    input  logic              start_irecv_wr,
    input  logic              cs_n,
    input  logic              dack_n,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              eop_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              drq,
    output logic              rdy,
    input  logic              scsi_req_i,
    input  logic              scsi_ack_i,
    output logic              scsi_req_o,
    output logic              scsi_ack_o,
    input  logic [DATA_W-1:0] scsi_din,
    output logic [DATA_W-1:0] scsi_dout,
    output logic              scsi_dout_en,
    output logic              busy,
    output logic              byte_done,
    output logic              eop_seen,
    output logic              cs_dack_err
);

    localparam int EDGE_W  = 3;
    localparam int E_DACK  = 0;
    localparam int E_IOR   = 1;
    localparam int E_IOW   = 2;

    typedef struct packed {
        sdh_state_e        st;
        xfer_kind_e        kind;
        logic              tgt;
        logic              blk;
        logic              done;
        logic              eop;
        logic              err;
        logic [DATA_W-1:0] hold;
    } seq_s;

    seq_s seq_d, seq_q;

    logic              accept;
    xfer_kind_e        acc_kind;
    logic [EDGE_W-1:0] rise;
    logic              is_send;
    logic              strb_n;
    logic              strb_rise;
    logic              clash;
    logic              bus_take;
    logic              bus_free;

    sdh_start_gate u_gate (
        .dma_mode       (dma_mode),
        .target_mode    (target_mode),
        .assert_data    (assert_data),
        .start_send_wr  (start_send_wr),
        .start_trecv_wr (start_trecv_wr),
        .start_irecv_wr (start_irecv_wr),
        .idle           (seq_q.st == ST_IDLE),
        .accept         (accept),
        .kind           (acc_kind)
    );

    sdh_edge_det #(.W(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n ({iow_n, ior_n, dack_n}),
        .rise  (rise)
    );

    always_comb begin
        is_send   = (seq_q.kind == XK_SEND);
        strb_n    = is_send ? iow_n : ior_n;
        strb_rise = is_send ? rise[E_IOW] : rise[E_IOR];
        clash     = !cs_n && !dack_n;
        bus_take  = seq_q.tgt ? scsi_ack_i  : scsi_req_i;
        bus_free  = seq_q.tgt ? !scsi_ack_i : !scsi_req_i;
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (clash)                              seq_d.err = 1'b1;
        if (!eop_n && seq_q.st != ST_IDLE)      seq_d.eop = 1'b1;

        if (is_send && !dack_n && !iow_n &&
            (seq_q.st == ST_HOST_REQ || seq_q.st == ST_HOST_END))
            seq_d.hold = host_wdata;

        if (!dma_mode) begin
            seq_d.st = ST_IDLE;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (accept) begin
                        seq_d.kind = acc_kind;
                        seq_d.tgt  = (acc_kind == XK_TRECV) ||
                                     (acc_kind == XK_SEND && target_mode);
                        seq_d.blk  = block_mode;
                        seq_d.st   = (acc_kind == XK_SEND) ? ST_HOST_REQ : ST_BUS_ACQ;
                        seq_d.err  = clash;
                        seq_d.eop  = 1'b0;
                    end
                end
                ST_BUS_ACQ: begin
                    if (bus_take) begin
                        seq_d.st = ST_BUS_REL;
                        if (!is_send) seq_d.hold = scsi_din;
                    end
                end
                ST_BUS_REL: begin
                    if (bus_free) seq_d.st = ST_HOST_REQ;
                end
                ST_HOST_REQ: begin
                    if (seq_q.blk ? (!dack_n && !strb_n) : !dack_n)
                        seq_d.st = ST_HOST_END;
                end
                ST_HOST_END: begin
                    if (seq_q.blk ? strb_rise : rise[E_DACK]) begin
                        seq_d.st   = ST_BUS_ACQ;
                        seq_d.done = 1'b1;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, kind: XK_SEND, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy         = (seq_q.st != ST_IDLE);
    assign drq          = (seq_q.st == ST_HOST_REQ) && !seq_q.blk;
    assign rdy          = (seq_q.st == ST_HOST_REQ) && seq_q.blk;
    assign scsi_req_o   = (seq_q.st == ST_BUS_ACQ) && seq_q.tgt;
    assign scsi_ack_o   = (seq_q.st == ST_BUS_REL) && !seq_q.tgt;
    assign scsi_dout    = seq_q.hold;
    assign scsi_dout_en = (seq_q.kind == XK_SEND) && assert_data &&
                          (seq_q.st == ST_BUS_ACQ || seq_q.st == ST_BUS_REL);
    assign host_rdata   = seq_q.hold;
    assign byte_done    = seq_q.done;
    assign eop_seen     = seq_q.eop;
    assign cs_dack_err  = seq_q.err;

endmodule

// File: rtl/sdh_checker.sv
module sdh_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_mode,
    input logic target_mode,
    input logic assert_data,
    input logic start_send_wr,
    input logic start_trecv_wr,
    input logic start_irecv_wr,
    input logic cs_n,
    input logic dack_n,
    input logic eop_n,
    input logic drq,
    input logic rdy,
    input logic scsi_req_i,
    input logic scsi_req_o,
    input logic scsi_ack_o,
    input logic scsi_dout_en,
    input logic busy,
    input logic cs_dack_err
);

    AST_DISABLED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dma_mode && (start_send_wr || start_trecv_wr || start_irecv_wr)) |=> !busy); // R1
    AST_ROLE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_send_wr && start_trecv_wr && !target_mode) |=> !busy); // R2
    AST_SEND_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_send_wr && !assert_data) |=> !busy); // R3
    AST_PACING_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drq && rdy)); // R4
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scsi_ack_o) |-> $past(scsi_req_i)); // R6
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_ack_o && scsi_req_i && dma_mode) |=> scsi_ack_o); // R6
    AST_REQ_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scsi_req_o && scsi_ack_o)); // R7
    AST_STOP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> !busy); // R8
    AST_EOP_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dma_mode && !eop_n) |=> busy); // R8
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !dack_n) |=> cs_dack_err); // R9
    AST_DRIVE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_dout_en |-> busy); // R10

endmodule

bind scsi_dma_handshake sdh_checker u_chk (.*);

// File: tb/sim_scsi_dma_handshake.sv
`timescale 1ns/1ps
module sim_scsi_dma_handshake;

    localparam int DW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dma_mode = 0, target_mode = 0, block_mode = 0, assert_data = 0;
    logic start_send_wr = 0, start_trecv_wr = 0, start_irecv_wr = 0;
    logic cs_n = 1, dack_n = 1, ior_n = 1, iow_n = 1, eop_n = 1;
    logic [DW-1:0] host_wdata = '0, scsi_din = '0;
    logic [DW-1:0] host_rdata, scsi_dout;
    logic drq, rdy, scsi_req_i = 0, scsi_ack_i = 0, scsi_req_o, scsi_ack_o;
    logic scsi_dout_en, busy, byte_done, eop_seen, cs_dack_err;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    scsi_dma_handshake #(.DATA_W(DW)) u0 (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {dma,tgt,drive,blk, kind(0 send,1 trecv,2 irecv), busy,req_o,drq,rdy}
    localparam logic [9:0] VEC [9] = '{
        {4'b0010, 2'd0, 4'b0000},
        {4'b1000, 2'd0, 4'b0000},
        {4'b1010, 2'd0, 4'b1010},
        {4'b1011, 2'd0, 4'b1001},
        {4'b1010, 2'd1, 4'b0000},
        {4'b1110, 2'd1, 4'b1100},
        {4'b1110, 2'd2, 4'b0000},
        {4'b1010, 2'd2, 4'b1000},
        {4'b1110, 2'd0, 4'b1010}
    };

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R8 reset busy", busy, 0);
        check("R4 reset drq", drq, 0);
        check("R5 reset rdy", rdy, 0);
        check("R7 reset req_o", scsi_req_o, 0);
        check("R6 reset ack_o", scsi_ack_o, 0);
        check("R9 reset err", cs_dack_err, 0);

        // start gating table: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 9; i++) begin
            {dma_mode, target_mode, assert_data, block_mode} = VEC[i][9:6];
            start_send_wr  = (VEC[i][5:4] == 2'd0);
            start_trecv_wr = (VEC[i][5:4] == 2'd1);
            start_irecv_wr = (VEC[i][5:4] == 2'd2);
            tick();
            start_send_wr = 0; start_trecv_wr = 0; start_irecv_wr = 0;
            check($sformatf("R1 R2 R3 vec%0d busy", i), busy, VEC[i][3]);
            check($sformatf("R7 vec%0d req_o", i), scsi_req_o, VEC[i][2]);
            check($sformatf("R4 vec%0d drq", i), drq, VEC[i][1]);
            check($sformatf("R5 vec%0d rdy", i), rdy, VEC[i][0]);
            dma_mode = 0;
            tick();
            check($sformatf("R8 vec%0d stop", i), busy, 0);
        end

        // initiator receive, interlocked
        dma_mode = 1; target_mode = 0; block_mode = 0; assert_data = 1;
        start_irecv_wr = 1; tick(); start_irecv_wr = 0;
        check("R6 wait req ack_o", scsi_ack_o, 0);
        scsi_din = 8'hA5; scsi_req_i = 1; tick();
        check("R6 ack after req", scsi_ack_o, 1);
        check("R10 rx latch", host_rdata, 8'hA5);
        check("R10 no drive on rx", scsi_dout_en, 0);
        scsi_din = 8'h00; eop_n = 0; tick(); eop_n = 1;
        check("R6 ack held", scsi_ack_o, 1);
        check("R8 eop no stop", busy, 1);
        check("R8 eop flag", eop_seen, 1);
        scsi_req_i = 0; tick();
        check("R6 ack release", scsi_ack_o, 0);
        check("R4 drq raised", drq, 1);
        dack_n = 0; ior_n = 0; tick();
        check("R4 drq drop on dack", drq, 0);
        ior_n = 1; tick();
        check("R4 strobe end ignored", byte_done, 0);
        check("R4 still busy", busy, 1);
        dack_n = 1; tick();
        check("R4 byte end on dack rise", byte_done, 1);
        check("R10 rx byte kept", host_rdata, 8'hA5);
        tick();
        check("R4 done pulse one cycle", byte_done, 0);
        dma_mode = 0; tick();
        check("R8 stop after rx", busy, 0);

        // target receive, block pacing
        dma_mode = 1; target_mode = 1; block_mode = 1;
        start_trecv_wr = 1; tick(); start_trecv_wr = 0;
        check("R8 eop flag cleared by start", eop_seen, 0);
        check("R7 req_o raised", scsi_req_o, 1);
        scsi_din = 8'h5A; scsi_ack_i = 1; tick();
        check("R7 req_o drop on ack", scsi_req_o, 0);
        check("R10 target rx latch", host_rdata, 8'h5A);
        check("R7 wait ack low", rdy, 0);
        scsi_ack_i = 0; tick();
        check("R5 rdy raised", rdy, 1);
        check("R5 no drq in block", drq, 0);
        dack_n = 0; cs_n = 0; tick(); cs_n = 1;
        check("R5 dack alone keeps rdy", rdy, 1);
        check("R9 clash flagged", cs_dack_err, 1);
        ior_n = 0; tick();
        check("R5 rdy drop on strobe", rdy, 0);
        ior_n = 1; tick();
        check("R5 end on strobe with dack held", byte_done, 1);
        check("R7 next byte req_o", scsi_req_o, 1);
        dma_mode = 0; dack_n = 1; tick();
        check("R8 stop releases req_o", scsi_req_o, 0);

        // send, initiator role, interlocked
        dma_mode = 1; target_mode = 0; block_mode = 0; assert_data = 1;
        start_send_wr = 1; tick(); start_send_wr = 0;
        check("R9 err cleared by start", cs_dack_err, 0);
        check("R3 send starts on host", drq, 1);
        check("R10 no drive before byte", scsi_dout_en, 0);
        host_wdata = 8'h3C; dack_n = 0; iow_n = 0; tick();
        iow_n = 1; host_wdata = 8'hFF; tick();
        dack_n = 1; tick();
        check("R4 send byte end", byte_done, 1);
        check("R10 tx data", scsi_dout, 8'h3C);
        check("R10 tx drive", scsi_dout_en, 1);
        scsi_req_i = 1; tick();
        check("R6 send ack", scsi_ack_o, 1);
        check("R10 tx data held", scsi_dout, 8'h3C);
        scsi_req_i = 0; tick();
        check("R6 send ack release", scsi_ack_o, 0);
        check("R10 drive off", scsi_dout_en, 0);
        start_irecv_wr = 1; tick(); start_irecv_wr = 0;
        check("R2 start while busy ignored", drq, 1);
        dma_mode = 0; tick();
        check("R8 final stop", busy, 0);
        check("R4 final drq", drq, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule